// File: doc/BRIEF.md
# Fuse Key Load Sequencer

This block loads the transmitter's secret keys from a fuse-backed store before any link authentication starts. A single start pulse launches a run. The block first checks that the power domain holding the key logic is up. It then asks a firmware mailbox to load the keys and watches the key status register until the load reports completion or a time budget runs out.

A good load ends with a single write that pushes the public key toward the link side. A failed attempt ends with a key wipe and a write-one-to-clear of the status register, and the block then tries again. The number of attempts has a fixed limit. The run ends with a one-cycle done pulse, a pass or fail verdict and the number of failed attempts.

The mailbox request is a valid/ready interface. The request stays valid, with a stable payload, until the responder takes it. The responder cannot stall the response, which comes back as a one-cycle valid pulse carrying an error flag. Every other pin is a plain level or pulse.

Top module: `keyload_seq`

## Requirements
- R1: If `pg_ready_i` is low when a start is taken, the block issues no mailbox request and pulses done one cycle later with `err_o` high and `retries_o` at 0.
- R2: Each attempt raises `mbox_valid_o` with opcode 0x05 and argument 1. The request stays valid and stable until the cycle in which `mbox_ready_i` is high.
- R3: If the mailbox response arrives with its error flag set, the attempt fails without polling the status.
- R4: While it waits for the load, the block samples `key_stat_i` once every `POLL_GAP` cycles. Bit 0 of the status is the load-done flag.
- R5: If load-done has not been seen at a sample by the end of `TIMEOUT_CYC` cycles of waiting, the attempt fails.
- R6: When load-done is seen, the attempt succeeds only if bit 1 (load passed) is also set. Otherwise it fails.
- R7: On success the block makes one key-config write with only bit 31 set. The next cycle it pulses done with `ok_o` high.
- R8: On a failed attempt the block makes one key-config write with only bit 30 set. The next cycle it makes one status write with mask 0xE3, which clears bits 7, 6, 5, 1 and 0.
- R9: The block makes at most `MAX_TRIES` attempts. If all of them fail, done pulses with `err_o` high and `retries_o` equal to `MAX_TRIES`.
- R10: `retries_o` counts the failed attempts of the latest run. It is cleared when a start is taken and holds its value after done.
- R11: `busy_o` is high from the cycle after a start is taken until done has pulsed. A start that arrives while the block is busy has no effect on the run.
- R12: Done is a single-cycle pulse. During it exactly one of `ok_o` and `err_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a run (taken only when idle) |
| pg_ready_i | input | 1 | Power domain with the key logic is up |
| mbox_valid_o | output | 1 | Mailbox request valid |
| mbox_ready_i | input | 1 | Mailbox takes the request |
| mbox_op_o | output | OP_W | Request opcode (0x05) |
| mbox_arg_o | output | ARG_W | Request argument (1) |
| mbox_rsp_valid_i | input | 1 | Mailbox response pulse |
| mbox_rsp_err_i | input | 1 | Response reports an error |
| key_stat_i | input | STAT_W | Key status register value |
| keycfg_we_o | output | 1 | Key-config write strobe |
| keycfg_wdata_o | output | CFG_W | Key-config write data |
| keystat_we_o | output | 1 | Status write strobe |
| keystat_wdata_o | output | STAT_W | Status write-one-to-clear mask |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Run finished (one cycle) |
| ok_o | output | 1 | Keys loaded, valid with done |
| err_o | output | 1 | Run failed, valid with done |
| retries_o | output | CNT_W | Failed attempts in the latest run |

## Verification
The hardest situation to reach is a run in which every attempt fails, each for a different reason: a mailbox error, a load that never completes, and a load that completes without the pass bit. It also has to keep the stale status bits of one attempt out of the next. The bench drives a behavioural fuse and mailbox responder from a per-attempt script. That script mixes these failure kinds across all five attempts, and one run also ends with a late success after two failures. A cycle-level model compares every output on every clock, and extra start pulses arrive in mid-run to show that they are ignored.

// File: rtl/keyload_pkg.sv
package keyload_pkg;

  typedef enum logic [2:0] {
    KL_IDLE,
    KL_REQ,
    KL_RESP,
    KL_POLL,
    KL_PUBLISH,
    KL_WIPE,
    KL_W1C,
    KL_REPORT
  } kl_state_e;

  localparam int         KCFG_PUBLISH_BIT = 31;
  localparam int         KCFG_WIPE_BIT    = 30;
  localparam int         KSTAT_DONE_BIT   = 0;
  localparam int         KSTAT_PASS_BIT   = 1;
  localparam logic [7:0] KSTAT_W1C_MASK   = 8'hE3;
  localparam logic [7:0] LOAD_OPCODE      = 8'h05;

endpackage

// File: rtl/keyload_poll_timer.sv
module keyload_poll_timer #(
  parameter int TIMEOUT_CYC = 50000,
  parameter int POLL_GAP    = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o,
  output logic expire_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int GW = $clog2(POLL_GAP + 1);

  logic [TW-1:0] elapsed_q;
  logic [GW-1:0] gap_q;

  assign tick_o   = run_i && (gap_q == GW'(POLL_GAP - 1));
  assign expire_o = run_i && (elapsed_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      elapsed_q <= '0;
      gap_q     <= '0;
    end else begin
      if (elapsed_q != TW'(TIMEOUT_CYC - 1)) elapsed_q <= elapsed_q + 1'b1;
      gap_q <= (gap_q == GW'(POLL_GAP - 1)) ? '0 : gap_q + 1'b1;
    end
  end

  generate
    if (POLL_GAP > 1) begin : g_spaced
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R4
    end
  endgenerate

endmodule

// File: rtl/keyload_try_ctr.sv
module keyload_try_ctr #(
  parameter int MAX_TRIES = 5,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) count_q <= '0;
    else if (inc_i)        count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
  assign last_o  = (count_q == CNT_W'(MAX_TRIES - 1));

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(MAX_TRIES)); // R9

endmodule

// File: rtl/keyload_seq.sv
module keyload_seq
  import keyload_pkg::*;
#(
  parameter int MAX_TRIES   = 5,
  parameter int TIMEOUT_CYC = 50000,
  parameter int POLL_GAP    = 5000,
  parameter int CFG_W       = 32,
  parameter int STAT_W      = 8,
  parameter int OP_W        = 8,
  parameter int ARG_W       = 32,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pg_ready_i,
  output logic              mbox_valid_o,
  input  logic              mbox_ready_i,
  output logic [OP_W-1:0]   mbox_op_o,
  output logic [ARG_W-1:0]  mbox_arg_o,
  input  logic              mbox_rsp_valid_i,
  input  logic              mbox_rsp_err_i,
  input  logic [STAT_W-1:0] key_stat_i,
  output logic              keycfg_we_o,
  output logic [CFG_W-1:0]  keycfg_wdata_o,
  output logic              keystat_we_o,
  output logic [STAT_W-1:0] keystat_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  retries_o
);

  kl_state_e st_q, st_d;
  logic      pass_q;
  logic      tick, expire, last_try;
  logic      run_start;

  assign run_start = (st_q == KL_IDLE) && start_i;

  keyload_poll_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .POLL_GAP   (POLL_GAP)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (st_q == KL_POLL),
    .tick_o  (tick),
    .expire_o(expire)
  );

  keyload_try_ctr #(
    .MAX_TRIES(MAX_TRIES)
  ) u_tries (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(run_start),
    .inc_i  (st_q == KL_W1C),
    .count_o(retries_o),
    .last_o (last_try)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KL_IDLE:    if (start_i) st_d = pg_ready_i ? KL_REQ : KL_REPORT;
      KL_REQ:     if (mbox_ready_i) st_d = KL_RESP;
      KL_RESP:    if (mbox_rsp_valid_i) st_d = mbox_rsp_err_i ? KL_WIPE : KL_POLL;
      KL_POLL: begin
        if (tick && key_stat_i[KSTAT_DONE_BIT])
          st_d = key_stat_i[KSTAT_PASS_BIT] ? KL_PUBLISH : KL_WIPE;
        else if (expire)
          st_d = KL_WIPE;
      end
      KL_PUBLISH: st_d = KL_REPORT;
      KL_WIPE:    st_d = KL_W1C;
      KL_W1C:     st_d = last_try ? KL_REPORT : KL_REQ;
      KL_REPORT:  st_d = KL_IDLE;
      default:    st_d = KL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= KL_IDLE;
      pass_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (run_start)               pass_q <= 1'b0;
      else if (st_q == KL_PUBLISH) pass_q <= 1'b1;
    end
  end

  assign mbox_valid_o = (st_q == KL_REQ);
  assign mbox_op_o    = OP_W'(LOAD_OPCODE);
  assign mbox_arg_o   = ARG_W'(1);

  always_comb begin
    keycfg_wdata_o = '0;
    if (st_q == KL_PUBLISH) keycfg_wdata_o[KCFG_PUBLISH_BIT] = 1'b1;
    if (st_q == KL_WIPE)    keycfg_wdata_o[KCFG_WIPE_BIT]    = 1'b1;
  end
  assign keycfg_we_o     = (st_q == KL_PUBLISH) || (st_q == KL_WIPE);
  assign keystat_we_o    = (st_q == KL_W1C);
  assign keystat_wdata_o = (st_q == KL_W1C) ? STAT_W'(KSTAT_W1C_MASK) : '0;

  assign busy_o = (st_q != KL_IDLE);
  assign done_o = (st_q == KL_REPORT);
  assign ok_o   = done_o && pass_q;
  assign err_o  = done_o && !pass_q;

  AST_PG_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && !pg_ready_i) |=> (done_o && err_o)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_valid_o && !mbox_ready_i) |=> (mbox_valid_o && $stable(mbox_op_o) && $stable(mbox_arg_o))); // R2
  AST_PUBLISH_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (keycfg_we_o && keycfg_wdata_o[KCFG_PUBLISH_BIT]) |=> (done_o && ok_o)); // R7
  AST_WIPE_THEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (keycfg_we_o && keycfg_wdata_o[KCFG_WIPE_BIT]) |=> keystat_we_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R12
  AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(keycfg_we_o && keystat_we_o)); // R8

endmodule

// File: tb/keyload_seq_bench.sv
module keyload_seq_bench;
  localparam int TO   = 60;
  localparam int GAP  = 8;
  localparam int MAXT = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start_i = 1'b0, pg_ready_i = 1'b1;
  logic mbox_ready_i = 1'b0, mbox_rsp_valid_i = 1'b0, mbox_rsp_err_i = 1'b0;
  logic [7:0] key_stat_i = '0;
  logic mbox_valid_o, keycfg_we_o, keystat_we_o, busy_o, done_o, ok_o, err_o;
  logic [7:0] mbox_op_o, keystat_wdata_o;
  logic [31:0] mbox_arg_o, keycfg_wdata_o;
  logic [2:0] retries_o;

  keyload_seq #(.MAX_TRIES(MAXT), .TIMEOUT_CYC(TO), .POLL_GAP(GAP)) u_keyload_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pg_ready_i(pg_ready_i),
    .mbox_valid_o(mbox_valid_o), .mbox_ready_i(mbox_ready_i),
    .mbox_op_o(mbox_op_o), .mbox_arg_o(mbox_arg_o),
    .mbox_rsp_valid_i(mbox_rsp_valid_i), .mbox_rsp_err_i(mbox_rsp_err_i),
    .key_stat_i(key_stat_i), .keycfg_we_o(keycfg_we_o), .keycfg_wdata_o(keycfg_wdata_o),
    .keystat_we_o(keystat_we_o), .keystat_wdata_o(keystat_wdata_o),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .err_o(err_o), .retries_o(retries_o));

  int n_checks = 0, n_fail = 0;

  task automatic check(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // per-attempt script: mailbox error, load delay (-1 never), pass bit
  int sc_err[MAXT], sc_delay[MAXT], sc_pass[MAXT];
  int att = 0, cur = 0, rsp_cd = -1, ld_cd = -1;
  bit prev_req = 0;
  int n_pub = 0, n_wipe = 0, n_w1c = 0;

  // behavioural reference: phase 0 idle,1 request,2 response,3 wait,4 publish,5 wipe,6 clear,7 report
  int m_ph = 0, m_k = 0, m_fails = 0;
  bit m_pass = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_fails = 0; m_pass = 0;
    end else begin
      case (m_ph)
        0: if (start_i) begin m_fails = 0; m_pass = 0; m_ph = pg_ready_i ? 1 : 7; end
        1: if (mbox_ready_i) m_ph = 2;
        2: if (mbox_rsp_valid_i) begin
             if (mbox_rsp_err_i) m_ph = 5; else begin m_ph = 3; m_k = 0; end
           end
        3: begin
             if (((m_k + 1) % GAP == 0) && key_stat_i[0]) m_ph = key_stat_i[1] ? 4 : 5;
             else if (m_k == TO - 1) m_ph = 5;
             else m_k++;
           end
        4: begin m_pass = 1; m_ph = 7; end
        5: m_ph = 6;
        6: begin m_fails++; m_ph = (m_fails == MAXT) ? 7 : 1; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      // cycle compare against the reference
      check("R11 busy", busy_o, m_ph != 0);
      check("R2 req_valid", mbox_valid_o, m_ph == 1);
      if (mbox_valid_o) begin
        check("R2 opcode", mbox_op_o, 8'h05);
        check("R2 argument", mbox_arg_o, 1);
      end
      check("R7 R8 cfg_we", keycfg_we_o, m_ph == 4 || m_ph == 5);
      check("R7 R8 cfg_data", keycfg_wdata_o,
            m_ph == 4 ? 32'h8000_0000 : (m_ph == 5 ? 32'h4000_0000 : 0));
      check("R8 stat_we", keystat_we_o, m_ph == 6);
      check("R8 stat_mask", keystat_wdata_o, m_ph == 6 ? 8'hE3 : 0);
      check("R12 done", done_o, m_ph == 7);
      check("R12 ok", ok_o, m_ph == 7 && m_pass);
      check("R12 err", err_o, m_ph == 7 && !m_pass);
      check("R10 retries", retries_o, m_fails);
      // responders
      mbox_rsp_valid_i = 1'b0;
      mbox_rsp_err_i   = 1'b0;
      if (rsp_cd == 0) begin
        mbox_rsp_valid_i = 1'b1;
        mbox_rsp_err_i   = sc_err[cur] != 0;
        if (sc_err[cur] == 0) ld_cd = sc_delay[cur];
        rsp_cd = -1;
      end else if (rsp_cd > 0) rsp_cd--;
      if (ld_cd == 0) begin
        key_stat_i = key_stat_i | 8'h01 | (sc_pass[cur] != 0 ? 8'h02 : 8'h00) | 8'h20;
        ld_cd = -1;
      end else if (ld_cd > 0) ld_cd--;
      if (keystat_we_o) begin key_stat_i = key_stat_i & ~keystat_wdata_o; n_w1c++; end
      if (keycfg_we_o && keycfg_wdata_o[31]) n_pub++;
      if (keycfg_we_o && keycfg_wdata_o[30]) n_wipe++;
      mbox_ready_i = mbox_valid_o && prev_req;
      prev_req = mbox_valid_o && !mbox_ready_i;
      if (mbox_valid_o && mbox_ready_i) begin
        cur = (att < MAXT) ? att : MAXT - 1;
        att++;
        rsp_cd = 2;
      end
    end
  end

  task automatic run_case(string name, bit pg, bit extra_start,
                          int e_ok, int e_retries, int e_att, int e_pub);
    int waited;
    @(negedge clk);
    key_stat_i = '0; att = 0; n_pub = 0; n_wipe = 0; n_w1c = 0;
    ld_cd = -1; rsp_cd = -1;
    pg_ready_i = pg;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 3000) begin
      @(negedge clk);
      waited++;
      if (extra_start && (waited == 3 || waited == 12)) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    check({name, " R12 done seen"}, done_o, 1);
    check({name, " R12 verdict ok"}, ok_o, e_ok);
    check({name, " R9 verdict err"}, err_o, !e_ok);
    check({name, " R10 retries"}, retries_o, e_retries);
    check({name, " R9 attempts"}, att, e_att);
    check({name, " R7 publishes"}, n_pub, e_pub);
    check({name, " R8 wipes"}, n_wipe, e_retries);
    check({name, " R8 status clears"}, n_w1c, e_retries);
    @(negedge clk);
    check({name, " R11 idle after"}, busy_o, 0);
    check({name, " R10 retries held"}, retries_o, e_retries);
  endtask

  task automatic set_try(int i, int err, int dly, int pass);
    sc_err[i] = err; sc_delay[i] = dly; sc_pass[i] = pass;
  endtask

  initial begin
    for (int i = 0; i < MAXT; i++) set_try(i, 0, 10, 1);
    repeat (3) @(negedge clk);
    check("R11 reset busy", busy_o, 0);
    check("R12 reset done", done_o, 0);
    check("R2 reset req", mbox_valid_o, 0);
    check("R10 reset retries", retries_o, 0);
    rst_n = 1'b1;

    // R1: power domain down
    run_case("pg_low R1", 1'b0, 1'b0, 0, 0, 0, 0);
    // R6 R11: clean first-try success with stray starts while busy
    set_try(0, 0, 20, 1);
    run_case("first_ok R6 R11", 1'b1, 1'b1, 1, 0, 1, 1);
    // R6: done without pass, then success
    set_try(0, 0, 10, 0); set_try(1, 0, 4, 1);
    run_case("nopass R6", 1'b1, 1'b0, 1, 1, 2, 1);
    // R3 R5: mailbox error, timeout, then success
    set_try(0, 1, 0, 0); set_try(1, 0, -1, 0); set_try(2, 0, 3, 1);
    run_case("err_to R3 R5", 1'b1, 1'b0, 1, 2, 3, 1);
    // R9: every attempt fails, mixed causes
    set_try(0, 1, 0, 0); set_try(1, 0, -1, 0); set_try(2, 0, 5, 0);
    set_try(3, 1, 0, 0); set_try(4, 0, -1, 0);
    run_case("all_fail R9", 1'b1, 1'b1, 0, 5, 5, 0);
    // R4 R5: load completes late in the window
    set_try(0, 0, 50, 1);
    run_case("late R4", 1'b1, 1'b0, 1, 0, 1, 1);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

endmodule